// File: doc/BRIEF.md
# Dual-Address DMA Channel

This block is one DMA channel that copies a run of data words from one memory-mapped location to another. Every word costs two bus operations. First the channel reads the word from the source address into an internal holding register. Then it writes that register to the destination address. After each write, both addresses step forward by one word and the remaining count drops by one.

Software programs the source, the destination and the word count through a small register port. It then writes the control register with the start bit set. That write picks the request source and arms the channel. While armed, the channel waits in standby. When a request is pending, it asks for the bus, and after the grant it moves words. When no request is pending, it hands the bus back and waits in standby again. Once the count runs out, or the bus reports an error, the channel goes back to idle. It records how the run ended and can raise an interrupt.

Top module: `dma_dual_chan`

## Requirements
- R1: A register write to offset 0 with bit 0 set, made while the channel is idle, arms the channel. Bit 0 of offset 0 reads 1 from arming until the channel is idle again, then reads 0 with no software action.
- R2: Each word is moved in this order: one read at the current source address, then one write of the data just read to the current destination address. After each successful write, the source (offset 1) and destination (offset 2) registers each grow by DW/8, and the count (offset 3) drops by one.
- R3: The channel raises `bus_req` only when a request is pending in standby, or while it is moving a word. It strobes `bus_rd` or `bus_wr` only while `bus_gnt` is high, and never both at once. It holds the strobe and the address until `bus_ready`.
- R4: After a successful write that does not end the run, the channel goes straight on to the next read if a request is still pending. Otherwise it drops `bus_req` and waits in standby.
- R5: When the count reaches zero after a write, the channel returns to idle and sets status bit 0 (offset 4). If the channel is armed with a count of zero, it completes the same way without any bus cycle.
- R6: A `bus_err` with `bus_ready` ends the run at once, returns the channel to idle and sets status bit 1. On a read, the pending write is not performed.
- R7: Bits [2:1] of offset 0 select the request source: 0 is software, 1 is the controller line, 2 is the device line on its falling edge, and 3 is the device line while it is low. In mode 0, arming alone starts the transfer.
- R8: In mode 1, nothing is transferred while `ctl_req_n` is high. Words move while it is low.
- R9: In mode 2, each falling edge of `dev_req_n` seen while the channel is armed moves exactly one word. An edge that arrives while an earlier one is still pending is merged with it.
- R10: In mode 3, words keep moving while `dev_req_n` is low. The line is sampled again at the end of every write.
- R11: `dev_ack_n` is low during every bus read and write in modes 2 and 3. It is high at all other times.
- R12: Status bits stay set until software writes 1 to them at offset 4. `irq` equals bit 3 of offset 0 ANDed with the OR of the two status bits.
- R13: Writes to offsets 0 to 3 are ignored while the channel is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DW | Write data from the holding register |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Access ended with an error, valid with `bus_ready` |
| ctl_req_n | input | 1 | Controller request line, active low |
| dev_req_n | input | 1 | Device request line |
| dev_ack_n | output | 1 | Device acknowledge, active low |
| irq | output | 1 | Completion interrupt |

## Verification
The bench targets six corner cases, each tied to a specific mistake:
- Releasing the level-mode device line in the middle of a run: a channel that does not sample the line again after each write would keep moving words, or would keep holding the bus.
- Single falling-edge pulses: a design that treats the edge as a level would move several words per pulse, or would stall.
- A read error: a design that gets this wrong still issues the write of stale data.
- A write error: a design that gets this wrong keeps counting.
- A zero count: without the check, the counter wraps and the channel starts a huge run.
- Register writes made while the channel is armed: without the lock, those writes would corrupt the running addresses.

Random bursts with random grant and ready delays show whether any address step or any hand-off of data through the holding register is lost.

// File: rtl/dma_dual_chan.sv
module dma_dual_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic          ctl_req_n,
  input  logic          dev_req_n,
  output logic          dev_ack_n,
  output logic          irq
);
  localparam int STEP = DW / 8;
  localparam logic [1:0] M_SW = 2'd0, M_CTL = 2'd1, M_EDGE = 2'd2, M_LVL = 2'd3;

  typedef enum logic [2:0] {IDLE, STBY, GNT, RD, WR} st_e;
  st_e st;

  logic [1:0]    mode;
  logic          ien, ok_f, err_f, dev_q, edge_p, pend;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hold;

  wire idle_wr  = cfg_we && st == IDLE;
  wire dev_fall = dev_q && !dev_req_n;
  wire rd_hs    = st == RD && bus_ready;
  wire wr_hs    = st == WR && bus_ready;
  wire wr_done  = wr_hs && !bus_err;
  wire last     = cnt == CW'(1);
  wire more     = (mode == M_EDGE) ? dev_fall : pend;

  always_comb begin
    case (mode)
      M_SW:    pend = 1'b1;
      M_CTL:   pend = !ctl_req_n;
      M_EDGE:  pend = edge_p;
      default: pend = !dev_req_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; mode <= M_SW; ien <= 1'b0; ok_f <= 1'b0; err_f <= 1'b0;
      src <= '0; dst <= '0; cnt <= '0; hold <= '0; dev_q <= 1'b1; edge_p <= 1'b0;
    end else begin
      dev_q <= dev_req_n;
      if (st == IDLE) edge_p <= 1'b0;
      else edge_p <= (edge_p && !wr_done) || (mode == M_EDGE && dev_fall);

      if (idle_wr) begin
        case (cfg_addr)
          3'd0: begin
            ien  <= cfg_wdata[3];
            mode <= cfg_wdata[2:1];
            if (cfg_wdata[0]) st <= STBY;
          end
          3'd1: src <= cfg_wdata[AW-1:0];
          3'd2: dst <= cfg_wdata[AW-1:0];
          3'd3: cnt <= cfg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (cfg_we && cfg_addr == 3'd4) begin
        if (cfg_wdata[0]) ok_f  <= 1'b0;
        if (cfg_wdata[1]) err_f <= 1'b0;
      end

      case (st)
        STBY: begin
          if (cnt == '0) begin st <= IDLE; ok_f <= 1'b1; end
          else if (pend) st <= GNT;
        end
        GNT: if (bus_gnt) st <= RD;
        RD: if (rd_hs) begin
          if (bus_err) begin st <= IDLE; err_f <= 1'b1; end
          else begin hold <= bus_rdata; st <= WR; end
        end
        WR: if (wr_hs) begin
          if (bus_err) begin st <= IDLE; err_f <= 1'b1; end
          else begin
            src <= src + AW'(STEP);
            dst <= dst + AW'(STEP);
            cnt <= cnt - CW'(1);
            if (last) begin st <= IDLE; ok_f <= 1'b1; end
            else st <= more ? RD : STBY;
          end
        end
        default: ;
      endcase
    end
  end

  assign bus_req   = st == GNT || st == RD || st == WR;
  assign bus_rd    = st == RD;
  assign bus_wr    = st == WR;
  assign bus_addr  = (st == WR) ? dst : src;
  assign bus_wdata = hold;
  assign dev_ack_n = !((st == RD || st == WR) && mode[1]);
  assign irq       = ien && (ok_f || err_f);

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {28'd0, ien, mode, st != IDLE};
      3'd1:    cfg_rdata = 32'(src);
      3'd2:    cfg_rdata = 32'(dst);
      3'd3:    cfg_rdata = 32'(cnt);
      3'd4:    cfg_rdata = {30'd0, err_f, ok_f};
      default: cfg_rdata = 32'd0;
    endcase
  end
endmodule

module dma_dual_chan_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_ready,
  input logic          bus_err,
  input logic [AW-1:0] bus_addr,
  input logic          dev_ack_n
);
  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));
  // R3
  strobe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd || bus_wr) |-> (bus_gnt && bus_req));
  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));
  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_ready && !bus_err) |=> bus_wr);
  // R6
  rd_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_ready && bus_err) |=> (!bus_wr && !bus_req));
  // R6
  wr_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready && bus_err) |=> (!bus_rd && !bus_req));
  // R11
  ack_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n) !dev_ack_n |-> (bus_rd || bus_wr));
endmodule

bind dma_dual_chan dma_dual_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_ready(bus_ready), .bus_err(bus_err), .bus_addr(bus_addr),
  .dev_ack_n(dev_ack_n)
);

// File: tb/tb_dma_dual_chan.sv
`timescale 1ns/1ps
module tb_dma_dual_chan;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic bus_req, bus_gnt = 0, bus_rd, bus_wr, bus_ready = 0, bus_err = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic ctl_req_n = 1, dev_req_n = 1, dev_ack_n, irq;

  int total = 0, bad = 0, rcnt = 0, wcnt = 0, cyc = 0;
  logic [31:0] exp_src = 0, exp_dst = 0;
  logic exp_dev = 0;
  logic [31:0] mem [256];

  always #2.5 clk = ~clk;

  dma_dual_chan dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .ctl_req_n(ctl_req_n), .dev_req_n(dev_req_n),
    .dev_ack_n(dev_ack_n), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus slave: decisions at the falling edge apply to the next rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 0; bus_ready = 0; bus_err = 0;
    end else begin
      bus_gnt = bus_req && (bus_gnt || ($urandom % 3 == 0));
      if (bus_rd || bus_wr) begin
        chk(dev_ack_n == !exp_dev, "R11 ack", {31'd0, dev_ack_n}, {31'd0, !exp_dev});
        bus_ready = ($urandom % 2) == 0;
        bus_err   = bus_addr[11];
        bus_rdata = mem[bus_addr[9:2]];
        if (bus_ready && bus_rd) begin
          chk(bus_addr == exp_src, "R2 src addr", bus_addr, exp_src);
          rcnt++;
        end
        if (bus_ready && bus_wr) begin
          chk(bus_addr == exp_dst, "R2 dst addr", bus_addr, exp_dst);
          chk(bus_wdata == mem[exp_src[9:2]], "R2 data", bus_wdata, mem[exp_src[9:2]]);
          if (!bus_err) begin
            mem[bus_addr[9:2]] = bus_wdata;
            exp_src += 4; exp_dst += 4; wcnt++;
          end
        end
      end else begin
        bus_ready = 0; bus_err = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #0.5; d = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); cfg_rd(3'd0, v);
      if (!v[0]) break;
    end
  endtask

  task automatic arm(input logic [1:0] m, input int n, input logic [31:0] s, input logic [31:0] d, input logic ie);
    exp_src = s; exp_dst = d; exp_dev = m[1];
    cfg_wr(3'd1, s); cfg_wr(3'd2, d); cfg_wr(3'd3, n); cfg_wr(3'd4, 32'd3);
    cfg_wr(3'd0, {28'd0, ie, m, 1'b1});
  endtask

  initial begin
    logic [31:0] v, s, d;
    int w0, r0, n, wi;
    logic [1:0] m;
    logic ie;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0 && bus_rd == 0 && bus_wr == 0, "R3 reset bus", {29'd0, bus_req, bus_rd, bus_wr}, 0);
    chk(irq == 0 && dev_ack_n == 1, "R12 reset irq/ack", {30'd0, irq, dev_ack_n}, 1);
    cfg_rd(3'd0, v); chk(v == 0, "R1 reset ctrl", v, 0);
    cfg_rd(3'd4, v); chk(v == 0, "R12 reset status", v, 0);

    // R5 zero count
    r0 = rcnt;
    arm(2'd0, 0, 32'h10, 32'h210, 1'b1);
    wait_idle();
    cfg_rd(3'd4, v); chk(v == 1, "R5 zero count status", v, 1);
    chk(rcnt == r0, "R5 zero count no bus", rcnt, r0);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R12 sticky irq", {31'd0, irq}, 1);
    cfg_wr(3'd4, 32'd1);
    chk(irq == 0, "R12 W1C irq", {31'd0, irq}, 0);
    cfg_rd(3'd4, v); chk(v == 0, "R12 W1C status", v, 0);

    // random runs in modes 0, 1, 3
    for (int it = 0; it < 24; it++) begin
      wi = $urandom % 3; m = (wi == 0) ? 2'd0 : (wi == 1) ? 2'd1 : 2'd3;
      n = 1 + $urandom % 6; ie = $urandom % 2;
      s = 4 * ($urandom % 64); d = 32'h200 + 4 * ($urandom % 64);
      for (int i = 0; i < 256; i++) mem[i] = $urandom;
      if (m == 2'd3) dev_req_n = 0;
      w0 = wcnt;
      arm(m, n, s, d, ie);
      if (m == 2'd1) begin
        repeat (10) @(negedge clk);
        chk(bus_req == 0, "R8 line high no req", {31'd0, bus_req}, 0);
        cfg_rd(3'd3, v); chk(v == n, "R8 line high count", v, n);
        ctl_req_n = 0;
      end
      wait_idle();
      cfg_rd(3'd0, v); chk(v[0] == 0, "R1 start clears", v, 0);
      cfg_rd(3'd4, v); chk(v == 1, "R5 ok status", v, 1);
      cfg_rd(3'd3, v); chk(v == 0, "R5 count zero", v, 0);
      cfg_rd(3'd1, v); chk(v == s + 4 * n, "R2 src advance", v, s + 4 * n);
      chk(wcnt - w0 == n, "R7 words moved", wcnt - w0, n);
      chk(irq == ie, "R12 irq enable", {31'd0, irq}, {31'd0, ie});
      for (int i = 0; i < n; i++)
        chk(mem[d[9:2] + i] == mem[s[9:2] + i], "R2 copy", mem[d[9:2] + i], mem[s[9:2] + i]);
      ctl_req_n = 1; dev_req_n = 1;
    end

    // R9 edge mode and R13 lock
    w0 = wcnt;
    arm(2'd2, 3, 32'h28, 32'h258, 1'b0);
    repeat (20) @(negedge clk);
    chk(wcnt == w0, "R9 no edge no word", wcnt, w0);
    for (int p = 1; p <= 3; p++) begin
      @(negedge clk); dev_req_n = 0;
      @(negedge clk); dev_req_n = 1;
      repeat (30) @(negedge clk);
      chk(wcnt - w0 == p, "R9 one word per edge", wcnt - w0, p);
      if (p == 1) begin
        chk(bus_req == 0, "R4 released", {31'd0, bus_req}, 0);
        cfg_rd(3'd3, v); chk(v == 2, "R9 count", v, 2);
        cfg_wr(3'd1, 32'h44);
        cfg_rd(3'd1, v); chk(v == 32'h2c, "R13 src locked", v, 32'h2c);
        cfg_wr(3'd3, 32'h9);
        cfg_rd(3'd3, v); chk(v == 2, "R13 count locked", v, 2);
      end
    end
    cfg_rd(3'd4, v); chk(v == 1, "R9 done", v, 1);

    // R10 level resample
    w0 = wcnt; dev_req_n = 0;
    arm(2'd3, 6, 32'h40, 32'h300, 1'b0);
    for (int i = 0; i < 500 && wcnt - w0 < 2; i++) @(negedge clk);
    dev_req_n = 1;
    repeat (20) @(negedge clk);
    n = wcnt - w0;
    cfg_rd(3'd0, v); chk(v[0] == 1, "R10 still armed", v, 1);
    chk(bus_req == 0, "R4 level released", {31'd0, bus_req}, 0);
    cfg_rd(3'd3, v); chk(v == 6 - n, "R10 count", v, 6 - n);
    repeat (20) @(negedge clk);
    chk(wcnt - w0 == n, "R10 stopped", wcnt - w0, n);
    dev_req_n = 0;
    wait_idle();
    chk(wcnt - w0 == 6, "R10 finished", wcnt - w0, 6);
    dev_req_n = 1;

    // R6 read error
    w0 = wcnt; r0 = rcnt;
    arm(2'd0, 2, 32'h800, 32'h220, 1'b1);
    wait_idle();
    cfg_rd(3'd4, v); chk(v == 2, "R6 read err status", v, 2);
    chk(wcnt == w0, "R6 no write after read err", wcnt, w0);
    chk(rcnt - r0 == 1, "R6 one read", rcnt - r0, 1);
    chk(irq == 1, "R12 err irq", {31'd0, irq}, 1);

    // R6 write error
    w0 = wcnt; r0 = rcnt;
    arm(2'd0, 2, 32'h14, 32'h900, 1'b0);
    wait_idle();
    cfg_rd(3'd4, v); chk(v == 2, "R6 write err status", v, 2);
    chk(wcnt == w0 && rcnt - r0 == 1, "R6 stop after write err", rcnt - r0, 1);
    cfg_rd(3'd3, v); chk(v == 2, "R6 count kept", v, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule